// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a high-rate oscillator clock by a programmable 16-bit ratio N. It does not count N directly. A small dual-modulus prescaler, which divides by 4 or by 5, feeds a 14-bit main counter. A 2-bit swallow counter decides how many main-counter steps use the divide-by-5 setting. With main value M and swallow value S, one output period therefore lasts 4M + S input clocks. In a frequency synthesizer the block sits in the feedback path between the oscillator and the phase comparator.

The ratio is split as follows. The low two bits of N give S, and the upper fourteen bits give M. A ratio below 28 cannot be built, because M must be at least 7. Such a ratio raises a combinational flag and is replaced by 28. The block picks up a new ratio only at a period boundary, so the period in progress always finishes with the old value. A disable input forces the output low, and the counters keep running underneath so that the output phase is kept.

Top module: `pswallow_div`

## Requirements
- R1: For any N from 28 to 65535, consecutive `div_o` pulses are exactly N input clocks apart.
- R2: N is split as S = N[1:0] and M = N[15:2], with period 4*M + S. For example, N = 12156 gives M = 3039 and S = 0.
- R3: In each period the prescaler divides by 5 for the first S main-counter steps and by 4 for the remaining M - S steps. The ratios 29 (S=1) and 31 (S=3) therefore give periods of 29 and 31.
- R4: When `div_n_i` is below 28, `n_invalid_o` is 1 in the same cycle and the block divides by 28. When `div_n_i` is 28 or more, `n_invalid_o` is 0.
- R5: While `out_dis_i` is 1, `div_o` is 0 from the next clock on. Counting continues, so the first pulse after re-enable falls on the original N-clock grid.
- R6: Each `div_o` pulse is high for exactly one input clock.
- R7: A new `div_n_i` is picked up at the next period boundary. The period in progress ends with the old ratio.
- R8: During reset `div_o` is 0. After reset is released, the first pulse appears on the (N+1)th rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_n_i | input | 16 | Total divide ratio N (S in bits 1:0, M in bits 15:2) |
| out_dis_i | input | 1 | 1 holds the divided output low |
| div_o | output | 1 | Divided output, a one-clock pulse per period |
| n_invalid_o | output | 1 | 1 when div_n_i is below the minimum ratio 28 |

## Verification
The results are due at different times:

- `n_invalid_o` is combinational, so the bench samples it one time unit after it drives `div_n_i`, within the same cycle.
- `div_o` is a registered copy of the terminal count. It rises on the clock edge that ends a period, so the bench measures periods as the number of falling-edge samples between two high samples.
- A ratio change takes effect one full period after it is driven. For this reason the bench discards the first pulse after each change before it measures.
- The disable path has one clock of latency. The first pulse after reset is due N+1 edges after reset is released, because one edge is spent loading the counters.

// File: rtl/psd_pkg.sv
package psd_pkg;
   // Default geometry of the divider
   localparam int DEF_N_W     = 16;
   localparam int DEF_PRE_DIV = 4;
   localparam int DEF_MIN_M   = 7;

   // Prescaler modulus selection
   typedef enum logic {
      MOD_LO = 1'b0,   // divide by PRE_DIV
      MOD_HI = 1'b1    // divide by PRE_DIV + 1
   } mod_e;
endpackage

// File: rtl/psd_decode.sv
module psd_decode #(
   parameter int N_W   = 16,
   parameter int SW    = 2,
   parameter int MW    = 14,
   parameter int N_MIN = 28
) (
   input  logic [N_W-1:0] n_i,
   output logic [MW-1:0]  m_o,
   output logic [SW-1:0]  s_o,
   output logic           invalid_o
);
   logic [N_W-1:0] n_eff;

   always_comb begin
      invalid_o = (n_i < N_W'(N_MIN));
      n_eff     = invalid_o ? N_W'(N_MIN) : n_i;
      s_o       = n_eff[SW-1:0];
      m_o       = n_eff[N_W-1:SW];
   end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
   parameter int PRE_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic mod_hi_i,
   output logic tick_o
);
   localparam int CW = $clog2(PRE_DIV + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;

   always_comb begin
      last   = mod_hi_i ? CW'(PRE_DIV) : CW'(PRE_DIV - 1);
      tick_o = (cnt_q == last);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (clear_i || tick_o) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/psd_counters.sv
module psd_counters
   import psd_pkg::*;
#(
   parameter int SW = 2,
   parameter int MW = 14
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [MW-1:0] m_i,
   input  logic [SW-1:0] s_i,
   input  logic          pre_tick_i,
   output logic          load_o,
   output logic          mod_hi_o,
   output logic          term_o,
   output logic          run_o,
   output logic [MW-1:0] mc_o,
   output logic [SW-1:0] sc_o
);
   logic          run_q;
   logic [MW-1:0] mc_q;
   logic [SW-1:0] sc_q;
   mod_e          mod_q;

   always_comb begin
      load_o   = !run_q;
      term_o   = run_q && pre_tick_i && (mc_q == MW'(1));
      mod_hi_o = (mod_q == MOD_HI);
      run_o    = run_q;
      mc_o     = mc_q;
      sc_o     = sc_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         mc_q  <= '0;
         sc_q  <= '0;
         mod_q <= MOD_LO;
      end else if (!run_q || term_o) begin
         // start of a period: reload both counters from the current ratio
         run_q <= 1'b1;
         mc_q  <= m_i;
         sc_q  <= s_i;
         mod_q <= (s_i != '0) ? MOD_HI : MOD_LO;
      end else if (pre_tick_i) begin
         mc_q <= mc_q - 1'b1;
         if (sc_q != '0) begin
            sc_q  <= sc_q - 1'b1;
            mod_q <= (sc_q != SW'(1)) ? MOD_HI : MOD_LO;
         end
      end
   end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
   parameter int N_W     = psd_pkg::DEF_N_W,
   parameter int PRE_DIV = psd_pkg::DEF_PRE_DIV,
   parameter int MIN_M   = psd_pkg::DEF_MIN_M
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [N_W-1:0] div_n_i,
   input  logic           out_dis_i,
   output logic           div_o,
   output logic           n_invalid_o
);
   localparam int SW    = $clog2(PRE_DIV);
   localparam int MW    = N_W - SW;
   localparam int N_MIN = PRE_DIV * MIN_M;

   generate
      if (PRE_DIV != (1 << SW)) begin : g_bad_pre
         $error("PRE_DIV must be a power of two");
      end
      if (MIN_M < PRE_DIV) begin : g_bad_min
         $error("MIN_M must be at least PRE_DIV so that M exceeds S");
      end
      if (N_W <= SW + 2) begin : g_bad_w
         $error("N_W too small for the prescaler");
      end
   endgenerate

   logic [MW-1:0] m_w;
   logic [SW-1:0] s_w;
   logic          pre_tick_w;
   logic          load_w;
   logic          mod_hi_w;
   logic          term_w;
   logic          run_w;
   logic [MW-1:0] mc_w;
   logic [SW-1:0] sc_w;
   logic          div_q;

   psd_decode #(.N_W(N_W), .SW(SW), .MW(MW), .N_MIN(N_MIN)) u_dec (
      .n_i       (div_n_i),
      .m_o       (m_w),
      .s_o       (s_w),
      .invalid_o (n_invalid_o)
   );

   psd_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (load_w),
      .mod_hi_i (mod_hi_w),
      .tick_o   (pre_tick_w)
   );

   psd_counters #(.SW(SW), .MW(MW)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .m_i        (m_w),
      .s_i        (s_w),
      .pre_tick_i (pre_tick_w),
      .load_o     (load_w),
      .mod_hi_o   (mod_hi_w),
      .term_o     (term_w),
      .run_o      (run_w),
      .mc_o       (mc_w),
      .sc_o       (sc_w)
   );

   // registered, gated output pulse
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q <= 1'b0;
      else         div_q <= term_w && !out_dis_i;
   end

   assign div_o = div_q;
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
   parameter int SW    = 2,
   parameter int MW    = 14,
   parameter int MIN_M = 7
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          out_dis_i,
   input logic          div_o,
   input logic          n_invalid_o,
   input logic [MW-1:0] m_w,
   input logic [SW-1:0] s_w,
   input logic          pre_tick_w,
   input logic          mod_hi_w,
   input logic          term_w,
   input logic          run_w,
   input logic [MW-1:0] mc_w,
   input logic [SW-1:0] sc_w
);
   // R5: disable forces the output low one clock later
   a_r5_dis_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_dis_i |=> !div_o);

   // R6: pulses last one clock
   a_r6_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_o |=> !div_o);

   // R3: divide-by-5 only while swallow steps remain
   a_r3_hi_needs_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w && mod_hi_w) |-> (sc_w != '0));

   // R3: last swallow step returns the prescaler to divide-by-4
   a_r3_hi_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w && pre_tick_w && !term_w && sc_w == SW'(1)) |=> !mod_hi_w);

   // R4: an invalid ratio decodes to the minimum main value and no swallow
   a_r4_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_invalid_o |-> (m_w == MW'(MIN_M) && s_w == '0));

   // R1: the main counter never sits at zero while running
   a_r1_main_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w |-> (mc_w != '0));
endmodule

bind pswallow_div pswallow_div_chk #(.SW(SW), .MW(MW), .MIN_M(MIN_M)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .out_dis_i   (out_dis_i),
   .div_o       (div_o),
   .n_invalid_o (n_invalid_o),
   .m_w         (m_w),
   .s_w         (s_w),
   .pre_tick_w  (pre_tick_w),
   .mod_hi_w    (mod_hi_w),
   .term_w      (term_w),
   .run_w       (run_w),
   .mc_w        (mc_w),
   .sc_w        (sc_w)
);

// File: tb/pswallow_div_tb_top.sv
module pswallow_div_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] div_n;
   logic        out_dis;
   logic        div_o;
   logic        n_invalid_o;

   int checks = 0;
   int errors = 0;

   localparam int NV = 9;
   localparam int VEC_N   [NV] = '{28, 29, 31, 30, 0, 27, 100, 12156, 65535};
   localparam int VEC_P   [NV] = '{28, 29, 31, 30, 28, 28, 100, 12156, 65535};
   localparam int VEC_INV [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0};

   always #4 clk = ~clk;   // 125 MHz

   pswallow_div dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .div_n_i     (div_n),
      .out_dis_i   (out_dis),
      .div_o       (div_o),
      .n_invalid_o (n_invalid_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts falling-edge samples until div_o is seen high
   task automatic wait_pulse(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!div_o);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int c;
      int ones;
      string tag;
      rst_n   = 1'b0;
      div_n   = 16'd28;
      out_dis = 1'b0;
      repeat (3) @(negedge clk);
      chk(div_o == 1'b0, "R8 reset output low", int'(div_o), 0);
      rst_n = 1'b1;

      // table walk: ratio, expected period, expected flag
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         div_n = 16'(VEC_N[i]);
         #1;
         chk(int'(n_invalid_o) == VEC_INV[i], "R4 invalid flag", int'(n_invalid_o), VEC_INV[i]);
         wait_pulse(c);   // period in progress ends, new ratio loads
         wait_pulse(c);
         if (VEC_INV[i] != 0)            tag = "R4 clamped period";
         else if (VEC_N[i] % 4 != 0)     tag = "R3 swallow period";
         else if (VEC_N[i] == 12156)     tag = "R2 split period";
         else                            tag = "R1 period";
         chk(c == VEC_P[i], tag, c, VEC_P[i]);
      end

      // R8: reset and first pulse after release
      @(negedge clk);
      rst_n = 1'b0;
      div_n = 16'd40;
      #1;
      chk(div_o == 1'b0, "R8 output low in reset", int'(div_o), 0);
      repeat (2) @(negedge clk);
      chk(div_o == 1'b0, "R8 output low in reset", int'(div_o), 0);
      rst_n = 1'b1;
      wait_pulse(c);
      chk(c == 41, "R8 first pulse", c, 41);

      // R6: one-clock pulse width
      @(negedge clk);
      chk(div_o == 1'b0, "R6 pulse width", int'(div_o), 0);
      wait_pulse(c);
      chk(c == 39, "R1 period after width check", c, 39);

      // R5: disable for 100 clocks, phase kept
      out_dis = 1'b1;
      ones = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (div_o) ones++;
      end
      chk(ones == 0, "R5 output held low", ones, 0);
      out_dis = 1'b0;
      wait_pulse(c);
      chk(c == 20, "R5 phase after re-enable", c, 20);

      // R7: ratio change waits for the period boundary
      div_n = 16'd50;
      wait_pulse(c);
      chk(c == 40, "R7 old ratio finishes", c, 40);
      wait_pulse(c);
      chk(c == 50, "R7 new ratio", c, 50);

      finish_run();
   end
endmodule